// File: doc/BRIEF.md
# Handshaked Output Port

This block is a single byte-wide output port that talks to a peripheral through a full/acknowledge handshake. When the host writes a byte, the byte is captured in a latch that drives the peripheral data lines, and an active-low buffer-full line drops to tell the peripheral that fresh data waits. The peripheral takes the byte and answers with an active-low acknowledge pulse. The end of that pulse (its rising edge, seen after a two-stage synchroniser) releases the buffer-full line. If the interrupt enable is on, the same event also raises an interrupt request toward the host. The next host write clears that request.

Control bits reach the block through a single-bit set/reset path. One bit index (parameter `INTE_BIT`, default 6) holds the interrupt enable. Indices 4 and 5 drive two general-purpose pins. Every other index is ignored. The handshake is a two-state machine. `ST_EMPTY` holds buffer-full high. `ST_FULL` holds it low. Transition `T_LOAD` (a write in either state) moves to or stays in `ST_FULL`. Transition `T_TAKEN` (acknowledge rising edge in `ST_FULL` with no write in the same cycle) returns to `ST_EMPTY`. An acknowledge edge in `ST_EMPTY` is `T_STRAY` and leaves the state as it is.

Top module: `hs_out_port`

## Requirements
- R1: After reset, `full_n_o` is 1, `irq_o` is 0, `pd_o` is 0x00, `gp_o` is 2'b00 and the interrupt enable is 0.
- R2: A clock edge that samples `wr_i`=1 loads `wr_data_i` onto `pd_o` and drives `full_n_o` to 0. `pd_o` does not change at any edge that samples `wr_i`=0.
- R3: In the full state, `full_n_o` returns to 1 at the third clock edge after `ack_n_i` rises. A low level on `ack_n_i` alone does not release it.
- R4: `irq_o` goes to 1 when an acknowledge ends a full handshake while the interrupt enable is 1. With the enable at 0, `irq_o` stays 0.
- R5: A host write clears `irq_o` at the same edge that loads the byte.
- R6: A write in the full state replaces the latched byte, and `full_n_o` stays 0.
- R7: An acknowledge rising edge in the empty state changes neither `full_n_o` nor `irq_o`.
- R8: When a write and the detected acknowledge edge fall in the same cycle, the write wins. The port stays full, `irq_o` stays 0, and the new byte is on `pd_o`.
- R9: A set/reset write with `bsr_bit_i`==`INTE_BIT` (default 6) sets the enable to `bsr_val_i`. Clearing the enable drops a pending `irq_o` within two clock edges.
- R10: Set/reset writes to index 4 and 5 drive `gp_o[0]` and `gp_o[1]`. Writes to any other index change neither `gp_o` nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Host write strobe, one cycle per byte |
| wr_data_i | input | 8 | Host write byte |
| bsr_wr_i | input | 1 | Single-bit set/reset write strobe |
| bsr_bit_i | input | 3 | Bit index of the set/reset write |
| bsr_val_i | input | 1 | Value written to the selected bit |
| ack_n_i | input | 1 | Active-low acknowledge from the peripheral (asynchronous) |
| pd_o | output | 8 | Latched data toward the peripheral |
| full_n_o | output | 1 | Active-low buffer-full toward the peripheral |
| irq_o | output | 1 | Interrupt request toward the host |
| gp_o | output | 2 | General-purpose pins (index 4, index 5) |

## Verification
The hardest case to reach is R8: a host write that lands in the exact cycle where the synchronised acknowledge edge is detected. Because of the synchroniser, that cycle comes two edges after the pin changes. The bench releases `ack_n_i` at a falling clock edge and lets two rising edges pass. It then raises `wr_i` so that the third rising edge sees both events. Mid-pulse sampling of `full_n_o` checks that only the rising edge of the acknowledge counts.

// File: rtl/hs_out_pkg.sv
package hs_out_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hs_state_e;

    localparam int unsigned GP_LO_BIT = 4;
    localparam int unsigned GP_HI_BIT = 5;
endpackage

// File: rtl/hs_ack_sync.sv
module hs_ack_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_i,
    output logic ack_rise_o
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], ack_n_i};
        end
    end

    assign ack_rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R3: an edge is only reported after the synchronised level went high
    a_r3_rise_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rise_o |=> !ack_rise_o);
endmodule

// File: rtl/hs_bsr_regs.sv
module hs_bsr_regs
    import hs_out_pkg::*;
#(
    parameter int unsigned BIT_W    = 3,
    parameter int unsigned INTE_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bsr_wr_i,
    input  logic [BIT_W-1:0] bsr_bit_i,
    input  logic             bsr_val_i,
    output logic             inte_o,
    output logic [1:0]       gp_o
);
    logic hit_inte, hit_lo, hit_hi;

    assign hit_inte = bsr_wr_i && (bsr_bit_i == BIT_W'(INTE_BIT));
    assign hit_lo   = bsr_wr_i && (bsr_bit_i == BIT_W'(GP_LO_BIT));
    assign hit_hi   = bsr_wr_i && (bsr_bit_i == BIT_W'(GP_HI_BIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inte_o <= 1'b0;
            gp_o   <= 2'b00;
        end else begin
            if (hit_inte) inte_o  <= bsr_val_i;
            if (hit_lo)   gp_o[0] <= bsr_val_i;
            if (hit_hi)   gp_o[1] <= bsr_val_i;
        end
    end

    // R10: pins only move on a set/reset write
    a_r10_gp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bsr_wr_i |=> $stable(gp_o));
    // R9: enable only moves on a set/reset write
    a_r9_inte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bsr_wr_i |=> $stable(inte_o));
endmodule

// File: rtl/hs_handshake_fsm.sv
module hs_handshake_fsm
    import hs_out_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ack_rise_i,
    input  logic              inte_i,
    output logic [DATA_W-1:0] pd_o,
    output logic              full_n_o,
    output logic              irq_o
);
    hs_state_e state_q, state_d;
    logic      irq_q, irq_d;
    logic      taken;

    assign taken = (state_q == ST_FULL) && ack_rise_i && !wr_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (wr_i) state_d = ST_FULL;            // T_LOAD (T_STRAY: stay)
            ST_FULL:  if (taken) state_d = ST_EMPTY;          // T_TAKEN, else T_LOAD/stay
        endcase
    end

    always_comb begin
        irq_d = irq_q;
        if (wr_i)          irq_d = 1'b0;
        else if (!inte_i)  irq_d = 1'b0;
        else if (taken)    irq_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            irq_q   <= 1'b0;
            pd_o    <= '0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
            if (wr_i) pd_o <= wr_data_i;
        end
    end

    always_comb begin
        full_n_o = (state_q != ST_FULL);
        irq_o    = irq_q;
    end

    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !full_n_o);
    a_r2_pd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(pd_o));
    a_r3_release_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_n_o) |-> $past(ack_rise_i));
    a_r4_irq_needs_inte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(inte_i) && $past(ack_rise_i)));
    a_r5_write_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !irq_o);
endmodule

// File: rtl/hs_out_port.sv
module hs_out_port
    import hs_out_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned BIT_W       = 3,
    parameter int unsigned INTE_BIT    = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              bsr_wr_i,
    input  logic [BIT_W-1:0]  bsr_bit_i,
    input  logic              bsr_val_i,
    input  logic              ack_n_i,
    output logic [DATA_W-1:0] pd_o,
    output logic              full_n_o,
    output logic              irq_o,
    output logic [1:0]        gp_o
);
    logic ack_rise;
    logic inte;

    hs_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_n_i    (ack_n_i),
        .ack_rise_o (ack_rise)
    );

    hs_bsr_regs #(.BIT_W(BIT_W), .INTE_BIT(INTE_BIT)) u_bsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bsr_wr_i  (bsr_wr_i),
        .bsr_bit_i (bsr_bit_i),
        .bsr_val_i (bsr_val_i),
        .inte_o    (inte),
        .gp_o      (gp_o)
    );

    hs_handshake_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_i),
        .wr_data_i  (wr_data_i),
        .ack_rise_i (ack_rise),
        .inte_i     (inte),
        .pd_o       (pd_o),
        .full_n_o   (full_n_o),
        .irq_o      (irq_o)
    );
endmodule

// File: tb/test_hs_out_port.sv
module test_hs_out_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       bsr_wr_i = 1'b0;
    logic [2:0] bsr_bit_i = 3'd0;
    logic       bsr_val_i = 1'b0;
    logic       ack_n_i = 1'b1;
    logic [7:0] pd_o;
    logic       full_n_o, irq_o;
    logic [1:0] gp_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    hs_out_port i_hs_out_port (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .wr_data_i(wr_data_i),
        .bsr_wr_i(bsr_wr_i), .bsr_bit_i(bsr_bit_i), .bsr_val_i(bsr_val_i),
        .ack_n_i(ack_n_i), .pd_o(pd_o), .full_n_o(full_n_o),
        .irq_o(irq_o), .gp_o(gp_o)
    );

    // vector: {op[1:0], arg[7:0], full_n, irq, gp[1:0], pd[7:0]}
    // op 0 write arg, op 1 ack pulse, op 2 set/reset (arg[3:1]=bit, arg[0]=value)
    localparam int NV = 16;
    localparam logic [21:0] VEC [NV] = '{
        {2'd0, 8'hA5, 1'b0, 1'b0, 2'b00, 8'hA5},  // R2 write
        {2'd1, 8'h00, 1'b1, 1'b0, 2'b00, 8'hA5},  // R3/R4 ack, enable off
        {2'd2, 8'h0D, 1'b1, 1'b0, 2'b00, 8'hA5},  // R9 enable on (bit 6)
        {2'd0, 8'h3C, 1'b0, 1'b0, 2'b00, 8'h3C},  // R2
        {2'd1, 8'h00, 1'b1, 1'b1, 2'b00, 8'h3C},  // R4 irq raised
        {2'd0, 8'h81, 1'b0, 1'b0, 2'b00, 8'h81},  // R5 write clears irq
        {2'd0, 8'h7E, 1'b0, 1'b0, 2'b00, 8'h7E},  // R6 overwrite while full
        {2'd1, 8'h00, 1'b1, 1'b1, 2'b00, 8'h7E},  // R4
        {2'd1, 8'h00, 1'b1, 1'b1, 2'b00, 8'h7E},  // R7 stray ack
        {2'd2, 8'h0C, 1'b1, 1'b0, 2'b00, 8'h7E},  // R9 clear enable drops irq
        {2'd2, 8'h09, 1'b1, 1'b0, 2'b01, 8'h7E},  // R10 bit 4 set
        {2'd2, 8'h0B, 1'b1, 1'b0, 2'b11, 8'h7E},  // R10 bit 5 set
        {2'd2, 8'h08, 1'b1, 1'b0, 2'b10, 8'h7E},  // R10 bit 4 clear
        {2'd2, 8'h07, 1'b1, 1'b0, 2'b10, 8'h7E},  // R10 bit 3 ignored
        {2'd0, 8'h00, 1'b0, 1'b0, 2'b10, 8'h00},  // R2
        {2'd1, 8'h00, 1'b1, 1'b0, 2'b10, 8'h00}   // R4 enable off, no irq
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_i = 1'b1; wr_data_i = d;
        @(negedge clk); wr_i = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk); ack_n_i = 1'b0;
        repeat (2) @(negedge clk);
        ack_n_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_bsr(input logic [2:0] b, input logic v);
        @(negedge clk); bsr_wr_i = 1'b1; bsr_bit_i = b; bsr_val_i = v;
        @(negedge clk); bsr_wr_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", {full_n_o, irq_o, gp_o, pd_o}, {1'b1, 1'b0, 2'b00, 8'h00});

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [7:0] arg;
            op  = VEC[i][21:20];
            arg = VEC[i][19:12];
            case (op)
                2'd0: do_write(arg);
                2'd1: do_ack();
                default: do_bsr(arg[3:1], arg[0]);
            endcase
            check($sformatf("R2-table step %0d", i), {full_n_o, irq_o, gp_o, pd_o}, VEC[i][11:0]);
        end

        // R3: low level of acknowledge alone does not release full
        do_bsr(3'd6, 1'b1);
        do_write(8'h55);
        @(negedge clk); ack_n_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R3 ack low holds full", {11'd0, full_n_o}, 12'd0);
        ack_n_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 not yet after two edges", {11'd0, full_n_o}, 12'd0);
        @(negedge clk);
        check("R3 released on third edge", {10'd0, full_n_o, irq_o}, {10'd0, 1'b1, 1'b1});

        // R8: write in the cycle the acknowledge edge is detected
        do_write(8'h12);
        @(negedge clk); ack_n_i = 1'b0;
        repeat (2) @(negedge clk);
        ack_n_i = 1'b1;
        repeat (2) @(negedge clk);
        wr_i = 1'b1; wr_data_i = 8'hC3;
        @(negedge clk); wr_i = 1'b0;
        check("R8 write wins", {full_n_o, irq_o, 2'b00, pd_o}, {1'b0, 1'b0, 2'b00, 8'hC3});
        repeat (3) @(negedge clk);
        check("R8 still full after", {11'd0, full_n_o}, 12'd0);

        // R1: reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset after activity", {full_n_o, irq_o, gp_o, pd_o}, {1'b1, 1'b0, 2'b00, 8'h00});
        // R9: enable is 0 after reset, so a handshake raises no irq
        do_write(8'h01);
        do_ack();
        check("R9 enable cleared by reset", {10'd0, full_n_o, irq_o}, {10'd0, 1'b1, 1'b0});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule